// File: doc/BRIEF.md
# Interrupt Pending and Vector Unit

This block holds the interrupt pending state of a small microcontroller core and tells the core which handler address to fetch next. Seven dedicated sources raise their pending bits with single-cycle request pulses. The eighth source, bit 0, is a shared line. It is driven by a secondary pending register that collects sub-events such as capture, compare, overrun and timer-overflow events, each gated by a secondary mask. Software can write the whole primary register, where a 1 raises an interrupt and a 0 cancels one, and it reads the register back through a data port.

On every cycle the unit takes the bits that are both pending and enabled, picks the highest-numbered one, and registers a request flag, the winner index and a 16-bit handler address equal to base + 2 × bit. The request flag is asserted only while the global enable is set. When the core reports that it took the vector, the winner's pending bit is cleared. The outputs of that same edge already show the next winner. The secondary pending bits are cleared when software reads them or writes a 1 over them. A reduced build leaves the top bits unimplemented through a parameter mask.

Top module: `irq_vector_unit`

## Requirements
- R1: After a synchronous reset, the primary pending register reads 00h, the secondary pending register reads 0 and `irq_req` is low.
- R2: A one-cycle pulse on `hw_req[k]` sets primary bit k at that clock edge. The bit is visible on `pend_rd_data` from that edge on and stays set after the pulse ends.
- R3: A software write (`sw_wr_en`) loads `sw_wr_data` into the primary register. A 1 sets a bit and a 0 clears it.
- R4: Among bits that are pending and have their `int_mask` bit at 1, the highest-numbered bit wins. A bit whose mask bit is 0 never wins.
- R5: `irq_req` is high only when `glb_en` is 1 and at least one pending bit is enabled. It is registered from the same edge as the pending register.
- R6: While `irq_req` is high, `irq_vector` equals VEC_BASE + 2 × winner (default VEC_BASE = 2000h, so bit 7 gives 200Eh and bit 0 gives 2000h).
- R7: When `vec_taken` is high while `irq_req` is high, the current winner's pending bit is cleared at that edge. `vec_taken` while `irq_req` is low has no effect.
- R8: A hardware set of a bit wins over a vector-taken clear of the same bit in the same cycle.
- R9: Precedence per bit is hardware set, then vector-taken clear, then software write. A software write of 0 cannot cancel a same-cycle hardware set, and a software write of 1 cannot override a same-cycle vector-taken clear.
- R10: Primary bit 0 is set on every cycle in which any secondary pending bit with its `sub_mask` bit at 1 is set. A secondary bit whose mask bit is 0 does not affect bit 0.
- R11: A pulse on `sub_evt[j]` sets secondary bit j. `sub_rd_en` clears all secondary bits, and `sub_wr_en` clears each bit written as 1. A sub-event in the same cycle as a clear wins.
- R12: Bits outside IMPL_MASK always read 0. Hardware requests and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NSRC-1 | Request pulses for sources 1..NSRC-1 (bit i of the port drives source i+1) |
| sw_wr_en | input | 1 | Software write strobe for the primary pending register |
| sw_wr_data | input | NSRC | Software write data for the primary pending register |
| pend_rd_data | output | NSRC | Primary pending register contents |
| int_mask | input | NSRC | Per-source enable |
| glb_en | input | 1 | Global interrupt enable |
| vec_taken | input | 1 | Core has transferred to the presented vector |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vector | output | VW | Registered handler address |
| sub_evt | input | NSUB | Sub-event pulses feeding the secondary register |
| sub_mask | input | NSUB | Secondary enable mask |
| sub_rd_en | input | 1 | Read strobe; clears the secondary register |
| sub_wr_en | input | 1 | Write strobe; clears the secondary bits written as 1 |
| sub_wr_data | input | NSUB | Secondary clear data |
| sub_rd_data | output | NSUB | Secondary pending register contents |

## Verification
The assertions check on every cycle that a hardware set always lands, that an acknowledged winner is cleared unless it is re-requested in the same cycle, and that a request never appears without the global enable. They also check that a presented vector is even and inside the table, that an enabled secondary bit always raises bit 0, and that a read with no new sub-event empties the secondary register. Only the directed scenarios can show which bit wins among several, the exact address for each bit, and how same-cycle set, clear and write collide. The scenarios also cover the masking of secondary bits and the fixed zeros of a reduced build.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_W_DEF  = 16;
  localparam int unsigned NSRC_DEF   = 8;
  localparam int unsigned NSUB_DEF   = 8;
  localparam logic [15:0] VEC_BASE_DEF = 16'h2000;
endpackage

// File: rtl/irq_sub_pend.sv
module irq_sub_pend #(
  parameter int unsigned NSUB = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSUB-1:0] evt,
  input  logic [NSUB-1:0] mask,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [NSUB-1:0] wr_data,
  output logic [NSUB-1:0] pend_q,
  output logic            mux_line
);
  logic [NSUB-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (rd_en) pend_d = '0;
    if (wr_en) pend_d = pend_d & ~wr_data;
    pend_d = pend_d | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign mux_line = |(pend_q & mask);

  // R11: read strobe without new events leaves the register empty
  p_rd_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(|evt)) |=> (pend_q == '0));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NSRC     = 8,
  parameter logic [NSRC-1:0] IMPL = '1,
  localparam int unsigned IW      = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_set,
  input  logic            sw_wr_en,
  input  logic [NSRC-1:0] sw_wr_data,
  input  logic            ack_valid,
  input  logic [IW-1:0]   ack_idx,
  output logic [NSRC-1:0] pend_d,
  output logic [NSRC-1:0] pend_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    if (IMPL[i]) begin : g_impl
      always_comb begin
        if (hw_set[i])                              pend_d[i] = 1'b1;
        else if (ack_valid && (ack_idx == IW'(i)))  pend_d[i] = 1'b0;
        else if (sw_wr_en)                          pend_d[i] = sw_wr_data[i];
        else                                        pend_d[i] = pend_q[i];
      end
    end else begin : g_rsv
      assign pend_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R2: a hardware set always lands
  p_hw_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|(hw_set & IMPL)) |=> ((pend_q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

  // R7: an acknowledged winner is cleared unless re-requested
  p_ack_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !hw_set[ack_idx]) |=> !pend_q[$past(ack_idx)]);
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
  parameter int unsigned NSRC     = 8,
  parameter int unsigned VW       = 16,
  parameter logic [VW-1:0] BASE   = 16'h2000,
  localparam int unsigned IW      = $clog2(NSRC),
  localparam logic [VW-1:0] VMAX  = BASE + VW'(2 * (NSRC - 1))
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_next,
  input  logic [NSRC-1:0] mask,
  input  logic            gie,
  output logic            irq_q,
  output logic [VW-1:0]   vec_q,
  output logic [IW-1:0]   win_q
);
  logic [NSRC-1:0] cand;
  logic            found;
  logic [IW-1:0]   idx;

  assign cand = pend_next & mask;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= BASE;
      win_q <= '0;
    end else begin
      irq_q <= gie & found;
      vec_q <= BASE + (VW'(idx) << 1);
      win_q <= idx;
    end
  end

  // R5: no request without the global enable
  p_gie_gate_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(gie));

  // R6: presented vector is even and inside the table
  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (!vec_q[0] && vec_q >= BASE && vec_q <= VMAX));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int unsigned NSRC      = NSRC_DEF,
  parameter int unsigned NSUB      = NSUB_DEF,
  parameter int unsigned VW        = VEC_W_DEF,
  parameter logic [VW-1:0] VEC_BASE = VEC_BASE_DEF,
  parameter logic [NSRC-1:0] IMPL_MASK = '1,
  localparam int unsigned IW       = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-2:0] hw_req,
  input  logic            sw_wr_en,
  input  logic [NSRC-1:0] sw_wr_data,
  output logic [NSRC-1:0] pend_rd_data,
  input  logic [NSRC-1:0] int_mask,
  input  logic            glb_en,
  input  logic            vec_taken,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vector,
  input  logic [NSUB-1:0] sub_evt,
  input  logic [NSUB-1:0] sub_mask,
  input  logic            sub_rd_en,
  input  logic            sub_wr_en,
  input  logic [NSUB-1:0] sub_wr_data,
  output logic [NSUB-1:0] sub_rd_data
);
  logic            mux_line;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] pend_d;
  logic [IW-1:0]   win_q;
  logic            ack_valid;

  irq_sub_pend #(.NSUB(NSUB)) u_sub (
    .clk(clk), .rst(rst), .evt(sub_evt), .mask(sub_mask),
    .rd_en(sub_rd_en), .wr_en(sub_wr_en), .wr_data(sub_wr_data),
    .pend_q(sub_rd_data), .mux_line(mux_line)
  );

  assign hw_set    = {hw_req, mux_line} & IMPL_MASK;
  assign ack_valid = vec_taken & irq_req;

  irq_pend_reg #(.NSRC(NSRC), .IMPL(IMPL_MASK)) u_pend (
    .clk(clk), .rst(rst), .hw_set(hw_set),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ack_valid(ack_valid), .ack_idx(win_q),
    .pend_d(pend_d), .pend_q(pend_rd_data)
  );

  irq_vec_sel #(.NSRC(NSRC), .VW(VW), .BASE(VEC_BASE)) u_sel (
    .clk(clk), .rst(rst), .pend_next(pend_d), .mask(int_mask),
    .gie(glb_en), .irq_q(irq_req), .vec_q(irq_vector), .win_q(win_q)
  );

  // R10: an enabled secondary bit raises primary bit 0
  p_mux_bit0_r10: assert property (@(posedge clk) disable iff (rst)
    (IMPL_MASK[0] && |(sub_rd_data & sub_mask)) |=> pend_rd_data[0]);
endmodule

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] hw_req = '0;
  logic       sw_wr_en = 1'b0;
  logic [7:0] sw_wr_data = '0;
  logic [7:0] int_mask = 8'hFF;
  logic       glb_en = 1'b1;
  logic       vec_taken = 1'b0;
  logic [7:0] sub_evt = '0, sub_mask = '0, sub_wr_data = '0;
  logic       sub_rd_en = 1'b0, sub_wr_en = 1'b0;
  logic [7:0] pend, pend_r, sub_rd, sub_rd_r;
  logic       irq, irq_r;
  logic [15:0] vec, vec_r;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .pend_rd_data(pend), .int_mask(int_mask),
    .glb_en(glb_en), .vec_taken(vec_taken), .irq_req(irq), .irq_vector(vec),
    .sub_evt(sub_evt), .sub_mask(sub_mask), .sub_rd_en(sub_rd_en),
    .sub_wr_en(sub_wr_en), .sub_wr_data(sub_wr_data), .sub_rd_data(sub_rd)
  );

  irq_vector_unit #(.IMPL_MASK(8'h3F)) i_irq_vector_unit_rsv (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .pend_rd_data(pend_r), .int_mask(int_mask),
    .glb_en(glb_en), .vec_taken(vec_taken), .irq_req(irq_r), .irq_vector(vec_r),
    .sub_evt(sub_evt), .sub_mask(sub_mask), .sub_rd_en(sub_rd_en),
    .sub_wr_en(sub_wr_en), .sub_wr_data(sub_wr_data), .sub_rd_data(sub_rd_r)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_hw(input int bitn);
    hw_req[bitn-1] = 1'b1; step(); hw_req = '0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sub", sub_rd, 8'h00);
  endtask

  task automatic t_hw_and_priority();
    pulse_hw(3);
    chk("R2 pend", pend, 8'h08);
    chk("R5 irq", irq, 1);
    chk("R6 vec bit3", vec, 16'h2006);
    step();
    chk("R2 sticky", pend, 8'h08);
    pulse_hw(5);
    chk("R4 highest wins", vec, 16'h200A);
    int_mask = 8'hDF; step();
    chk("R4 masked bit", vec, 16'h2006);
    int_mask = 8'hFF; glb_en = 1'b0; step();
    chk("R5 gie off", irq, 0);
    glb_en = 1'b1; step();
    chk("R5 gie on", irq, 1);
  endtask

  task automatic t_ack();
    vec_taken = 1'b1; step(); vec_taken = 1'b0;
    chk("R7 ack clears bit5", pend, 8'h08);
    chk("R7 next vector", vec, 16'h2006);
    hw_req[2] = 1'b1; vec_taken = 1'b1; step(); hw_req = '0; vec_taken = 1'b0;
    chk("R8 set beats ack", pend, 8'h08);
    vec_taken = 1'b1; step(); vec_taken = 1'b0;
    chk("R7 last clear", pend, 8'h00);
    chk("R7 irq drops", irq, 0);
    vec_taken = 1'b1; step(); vec_taken = 1'b0;
    chk("R7 ack when idle", pend, 8'h00);
  endtask

  task automatic t_sw();
    sw_wr_en = 1'b1; sw_wr_data = 8'h81; step(); sw_wr_en = 1'b0;
    chk("R3 write ones", pend, 8'h81);
    chk("R6 vec bit7", vec, 16'h200E);
    sw_wr_en = 1'b1; sw_wr_data = 8'h00; step(); sw_wr_en = 1'b0;
    chk("R3 write zeros", pend, 8'h00);
    sw_wr_en = 1'b1; sw_wr_data = 8'h00; hw_req[1] = 1'b1; step();
    sw_wr_en = 1'b0; hw_req = '0;
    chk("R9 hw beats sw", pend, 8'h04);
    sw_wr_en = 1'b1; sw_wr_data = 8'h04; vec_taken = 1'b1; step();
    sw_wr_en = 1'b0; vec_taken = 1'b0;
    chk("R9 ack beats sw", pend, 8'h00);
  endtask

  task automatic t_sub();
    sub_mask = 8'h01; sub_evt = 8'h10; step(); sub_evt = '0;
    chk("R11 sub set", sub_rd, 8'h10);
    step();
    chk("R10 masked sub", pend, 8'h00);
    sub_mask = 8'h10; step();
    chk("R10 bit0 set", pend, 8'h01);
    chk("R6 vec bit0", vec, 16'h2000);
    sub_rd_en = 1'b1; step(); sub_rd_en = 1'b0;
    chk("R11 read clears", sub_rd, 8'h00);
    vec_taken = 1'b1; step(); vec_taken = 1'b0;
    chk("R10 bit0 cleared", pend, 8'h00);
    sub_evt = 8'h06; step(); sub_evt = '0;
    sub_wr_en = 1'b1; sub_wr_data = 8'h02; step(); sub_wr_en = 1'b0;
    chk("R11 write one clears", sub_rd, 8'h04);
    sub_rd_en = 1'b1; sub_evt = 8'h01; step(); sub_rd_en = 1'b0; sub_evt = '0;
    chk("R11 event beats read", sub_rd, 8'h01);
    sub_rd_en = 1'b1; step(); sub_rd_en = 1'b0;
  endtask

  task automatic t_reserved();
    sw_wr_en = 1'b1; sw_wr_data = 8'hFF; step(); sw_wr_en = 1'b0;
    chk("R12 rsv write", pend_r, 8'h3F);
    chk("R3 full write", pend, 8'hFF);
    sw_wr_en = 1'b1; sw_wr_data = 8'h00; step(); sw_wr_en = 1'b0;
    pulse_hw(7);
    chk("R12 rsv hw ignored", pend_r, 8'h00);
    chk("R2 bit7 set", pend, 8'h80);
  endtask

  initial begin : watchdog
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_hw_and_priority();
    t_ack();
    t_sw();
    t_sub();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule